// File: doc/BRIEF.md
# Guarded Write Bridge for Upset-Tolerant Memory

This block sits between a processor and a memory that must not be corrupted by an upset. The processor sees a plain SRAM-style port with active-low select, write and read strobes, address and write data. When the processor writes, the bridge captures address and data into its own registers. It pulses an active-low capture strobe, then waits a fixed guard time before it drives an active-low write strobe to the memory. An active-low inhibit input, raised by upset detection, can cancel the pending write at any point before the memory strobe begins. A write disturbed by an upset therefore never reaches the protected array.

An acknowledge output serves processors that stretch their bus cycles with automatic wait states. It pulses once per completed write and once per read. The captured address stays visible on the memory address port until the next write is captured, so it records the last address presented. A separate recall register holds the last address actually committed to memory. After an upset, recovery software can compare the two to see which write was lost.

Default timing assumes a 66 MHz clock: a 2-cycle guard (about 30 ns) between the capture cycle and the memory strobe, and a 2-cycle strobe.

Top module: `guarded_write_bridge`

## Requirements
- R1: In the idle state, a clock edge that samples sel_n=0 and wr_n=0 loads addr and wdata into mem_addr and mem_wdata, and cap_n is low for exactly the one cycle that follows that edge.
- R2: mem_we_n goes low on the third clock edge after the capture edge, which leaves GUARD_CYC=2 full cycles between the capture cycle and the strobe.
- R3: Once mem_we_n goes low it stays low for STROBE_CYC=2 cycles and then returns high. Inhibit does not shorten a strobe that has already begun.
- R4: If inhibit_n is sampled low on any of the three edges after the capture edge, including the edge that would start the strobe, the write is dropped. mem_we_n stays high, no acknowledge is given and last_mem_addr keeps its value.
- R5: For a committed write, ack is high for exactly one cycle, starting at the edge where mem_we_n returns high.
- R6: In the idle state, an edge that samples sel_n=0, rd_n=0 and wr_n=1 raises ack for exactly the one following cycle. No capture happens and mem_we_n stays high.
- R7: While sel_n is high, the write and read strobes have no effect: cap_n and mem_we_n stay high, ack stays low and mem_addr is unchanged.
- R8: A new request is accepted only after both wr_n and rd_n have been sampled high. A strobe held low past the end of its transaction does not start a second one.
- R9: last_mem_addr takes the captured address on the edge where mem_we_n goes low. mem_addr holds the last captured address until the next capture.
- R10: An edge that samples rst_n low forces mem_we_n and cap_n high, ack low, mem_addr, mem_wdata and last_mem_addr to zero, and drops any pending write.
- R11: When wr_n and rd_n are both low in the idle state, the write is taken and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Block select from the processor, active low |
| inhibit_n | input | 1 | Upset inhibit, active low; cancels a pending write |
| wr_n | input | 1 | Processor write strobe, active low |
| rd_n | input | 1 | Processor read strobe, active low |
| addr | input | AW | Processor address |
| wdata | input | DW | Processor write data |
| mem_we_n | output | 1 | Delayed memory write strobe, active low |
| cap_n | output | 1 | Capture strobe, active low, one cycle per accepted write |
| ack | output | 1 | Acknowledge pulse for wait-state control |
| mem_addr | output | AW | Captured address driven to memory |
| mem_wdata | output | DW | Captured data driven to memory |
| last_mem_addr | output | AW | Recall of the last address committed to memory |

## Verification
A wrong sequencer state shows at the ports within a few cycles of the capture edge. It appears as a memory strobe one cycle early or late, of the wrong width, or missing, or as an acknowledge that is absent or doubled. A wrong guard counter or a lost inhibit is seen at the third edge after capture, where mem_we_n and last_mem_addr are compared with the expected commit or drop. A wrong capture or recall register is visible at once on mem_addr, mem_wdata or last_mem_addr, which the bench compares against its own record of committed writes.

// File: rtl/gwb_pkg.sv
// Package: shared types for the guarded write bridge.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package gwb_pkg;

    // Sequencer states of the bridge controller.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // waiting for a request
        ST_GUARD  = 3'd1,   // write captured, guard time running
        ST_STROBE = 3'd2,   // memory write strobe active
        ST_WACK   = 3'd3,   // write acknowledge cycle
        ST_RACK   = 3'd4,   // read acknowledge cycle
        ST_REL    = 3'd5    // waiting for processor strobes to release
    } gwb_state_e;

endpackage

// File: rtl/gwb_ctrl.sv
// Module: gwb_ctrl
// Sequences one transaction at a time: capture, guard wait, memory
// strobe, acknowledge, then wait for the processor strobes to release.
// Assumes: strobes are synchronous to clk; reset is synchronous, active low.
module gwb_ctrl #(
    parameter int GUARD_CYC  = 2,
    parameter int STROBE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic inhibit_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic cap_en,
    output logic commit_en,
    output logic cap_n_q,
    output logic we_n_q,
    output logic ack_q
);
    import gwb_pkg::*;

    localparam int CMAX = (GUARD_CYC > STROBE_CYC) ? GUARD_CYC : STROBE_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    gwb_state_e    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          wr_req, rd_req;

    assign wr_req = !sel_n && !wr_n;
    assign rd_req = !sel_n && !rd_n;

    // Next-state decode, guard/strobe counting and enable pulses.
    always_comb begin
        state_nx  = state;
        cnt_nx    = cnt;
        cap_en    = 1'b0;
        commit_en = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_req) begin
                    cap_en   = 1'b1;
                    cnt_nx   = '0;
                    state_nx = ST_GUARD;
                end else if (rd_req) begin
                    state_nx = ST_RACK;
                end
            end
            ST_GUARD: begin
                if (!inhibit_n) begin
                    state_nx = ST_REL;
                end else if (cnt == CW'(GUARD_CYC)) begin
                    commit_en = 1'b1;
                    cnt_nx    = '0;
                    state_nx  = ST_STROBE;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt == CW'(STROBE_CYC - 1)) begin
                    state_nx = ST_WACK;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_WACK:  state_nx = ST_REL;
            ST_RACK:  state_nx = ST_REL;
            ST_REL: begin
                if (wr_n && rd_n) state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State, counter and registered output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            cap_n_q <= 1'b1;
            we_n_q  <= 1'b1;
            ack_q   <= 1'b0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            cap_n_q <= !cap_en;
            we_n_q  <= (state_nx != ST_STROBE);
            ack_q   <= (state_nx == ST_WACK) || (state_nx == ST_RACK);
        end
    end

    // Capture strobe and memory strobe are never active together.
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cap_n_q && !we_n_q));

    // Write acknowledge rises on the edge that ends the memory strobe.
    assert_ack_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n_q) && $past(rst_n)) |-> ack_q);

    // An inhibit sampled during the guard time blocks the strobe.
    assert_inhibit_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GUARD && !inhibit_n) |=> we_n_q);

    // Reset drives all strobes inactive.
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (we_n_q && cap_n_q && !ack_q));

    // The strobe width check applies only to multi-cycle strobes.
    generate
        if (STROBE_CYC >= 2) begin : g_wide_strobe
            assert_strobe_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(we_n_q) |=> !we_n_q);
        end
    endgenerate

endmodule

// File: rtl/gwb_capture.sv
// Module: gwb_capture
// Holds the address and data of the most recently accepted write and
// drives them to the memory.
// Assumes: cap_en is a one-cycle pulse from the controller.
module gwb_capture #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    // Load address and data on capture, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (cap_en) begin
            addr_q <= addr;
            data_q <= wdata;
        end
    end

    // Captured address changes only on a capture pulse.
    assert_cap_only_on_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(addr_q) && $past(rst_n)) |-> $past(cap_en));

endmodule

// File: rtl/gwb_recall.sv
// Module: gwb_recall
// Records the address of the last write that actually reached memory.
// Assumes: commit_en pulses once, on the edge that starts the strobe.
module gwb_recall #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_en,
    input  logic [AW-1:0] addr_q,
    output logic [AW-1:0] last_mem_addr
);

    // Copy the captured address when the write is committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_mem_addr <= '0;
        end else if (commit_en) begin
            last_mem_addr <= addr_q;
        end
    end

    // Recall register moves only on a commit.
    assert_recall_on_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(last_mem_addr) && $past(rst_n)) |-> $past(commit_en));

endmodule

// File: rtl/guarded_write_bridge.sv
// Module: guarded_write_bridge (top)
// SRAM-style processor port in front of an upset-protected memory. Writes are
// captured, held for a guard time, cancellable by inhibit, then strobed.
// Assumes: single clock domain; synchronous active-low reset.
module guarded_write_bridge #(
    parameter int AW         = 20,
    parameter int DW         = 16,
    parameter int GUARD_CYC  = 2,
    parameter int STROBE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          inhibit_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          mem_we_n,
    output logic          cap_n,
    output logic          ack,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] last_mem_addr
);

    logic cap_en;
    logic commit_en;

    gwb_ctrl #(
        .GUARD_CYC  (GUARD_CYC),
        .STROBE_CYC (STROBE_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .inhibit_n (inhibit_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .cap_en    (cap_en),
        .commit_en (commit_en),
        .cap_n_q   (cap_n),
        .we_n_q    (mem_we_n),
        .ack_q     (ack)
    );

    gwb_capture #(
        .AW (AW),
        .DW (DW)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .addr   (addr),
        .wdata  (wdata),
        .addr_q (mem_addr),
        .data_q (mem_wdata)
    );

    gwb_recall #(
        .AW (AW)
    ) u_recall (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_en     (commit_en),
        .addr_q        (mem_addr),
        .last_mem_addr (last_mem_addr)
    );

endmodule

// File: tb/guarded_write_bridge_bench.sv
// Bench for guarded_write_bridge: vector table of writes, then directed tests.
module guarded_write_bridge_bench;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int NV = 6;

    // Write vectors: address, data, edge after capture at which inhibit is
    // sampled low (0 = never, so the write commits).
    localparam logic [AW-1:0] T_ADDR [0:NV-1] = '{20'h12345, 20'h00001, 20'hFFFFF,
                                                  20'h0A5A5, 20'h54321, 20'h80000};
    localparam logic [DW-1:0] T_DATA [0:NV-1] = '{16'hBEEF, 16'h0001, 16'hFFFF,
                                                  16'h5A5A, 16'h1234, 16'h8000};
    localparam int            T_INH  [0:NV-1] = '{0, 1, 0, 3, 2, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          inhibit_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          rd_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          mem_we_n, cap_n, ack;
    logic [AW-1:0] mem_addr, last_mem_addr;
    logic [DW-1:0] mem_wdata;

    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;
    logic [AW-1:0] exp_last = '0;

    always #10 clk = ~clk;

    guarded_write_bridge #(.AW(AW), .DW(DW)) u_guarded_write_bridge (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .inhibit_n(inhibit_n),
        .wr_n(wr_n), .rd_n(rd_n), .addr(addr), .wdata(wdata),
        .mem_we_n(mem_we_n), .cap_n(cap_n), .ack(ack),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .last_mem_addr(last_mem_addr)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One write; inh selects the edge after capture at which inhibit is low.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int inh, input int hold);
        bit commit = (inh == 0);
        sel_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d; inhibit_n = 1'b1;
        cycle();
        chk(cap_n == 1'b0, "R1 cap_n", 32'(cap_n), 0);
        chk(mem_addr == a, "R1 mem_addr", 32'(mem_addr), 32'(a));
        chk(mem_wdata == d, "R1 mem_wdata", 32'(mem_wdata), 32'(d));
        if (inh == 1) inhibit_n = 1'b0;
        for (int e = 1; e <= 6; e++) begin
            cycle();
            if (e == 1) begin
                chk(cap_n == 1'b1, "R1 cap_n width", 32'(cap_n), 1);
                chk(mem_we_n == 1'b1, "R2 early strobe", 32'(mem_we_n), 1);
                if (inh == 2) inhibit_n = 1'b0;
            end else if (e == 2) begin
                chk(mem_we_n == 1'b1, "R2 early strobe", 32'(mem_we_n), 1);
                if (inh == 3) inhibit_n = 1'b0;
            end else if (e == 3) begin
                if (commit) begin
                    chk(mem_we_n == 1'b0, "R2 strobe start", 32'(mem_we_n), 0);
                    chk(last_mem_addr == a, "R9 recall", 32'(last_mem_addr), 32'(a));
                end else begin
                    chk(mem_we_n == 1'b1, "R4 dropped strobe", 32'(mem_we_n), 1);
                    chk(last_mem_addr == exp_last, "R4 recall kept",
                        32'(last_mem_addr), 32'(exp_last));
                end
            end else if (e == 4) begin
                chk(mem_we_n == !commit, "R3 strobe held", 32'(mem_we_n), 32'(!commit));
                chk(ack == 1'b0, "R5 ack early", 32'(ack), 0);
            end else if (e == 5) begin
                chk(mem_we_n == 1'b1, "R3 strobe end", 32'(mem_we_n), 1);
                chk(ack == commit, commit ? "R5 ack" : "R4 no ack", 32'(ack), 32'(commit));
            end else begin
                chk(ack == 1'b0, "R5 ack width", 32'(ack), 0);
                chk(mem_addr == a, "R9 mem_addr kept", 32'(mem_addr), 32'(a));
            end
        end
        if (commit) exp_last = a;
        // R8: a held strobe with a new address must not start a new write.
        addr = ~a;
        for (int h = 0; h < hold; h++) begin
            cycle();
            chk(cap_n == 1'b1 && mem_we_n == 1'b1, "R8 no retrigger",
                32'({cap_n, mem_we_n}), 3);
            chk(mem_addr == a, "R8 mem_addr", 32'(mem_addr), 32'(a));
        end
        sel_n = 1'b1; wr_n = 1'b1; inhibit_n = 1'b1;
        cycle();
        cycle();
    endtask

    initial begin
        @(negedge clk);
        cycle();
        cycle();
        // R10: reset state.
        chk(mem_we_n == 1'b1 && cap_n == 1'b1 && ack == 1'b0, "R10 reset strobes",
            32'({mem_we_n, cap_n, ack}), 32'b110);
        chk(mem_addr == '0 && last_mem_addr == '0, "R10 reset regs",
            32'(mem_addr | last_mem_addr), 0);
        rst_n = 1'b1;
        cycle();

        // Vector table walk (R1-R5, R9).
        for (int v = 0; v < NV; v++) begin
            do_write(T_ADDR[v], T_DATA[v], T_INH[v], 0);
        end

        // R8: write with strobe held after completion.
        do_write(20'h33333, 16'h3333, 0, 4);

        // R6: read acknowledge.
        sel_n = 1'b0; rd_n = 1'b0;
        cycle();
        chk(ack == 1'b1, "R6 read ack", 32'(ack), 1);
        chk(cap_n == 1'b1 && mem_we_n == 1'b1, "R6 no capture", 32'({cap_n, mem_we_n}), 3);
        cycle();
        chk(ack == 1'b0, "R6 read ack width", 32'(ack), 0);
        cycle();
        chk(ack == 1'b0, "R8 held read", 32'(ack), 0);
        sel_n = 1'b1; rd_n = 1'b1;
        cycle();

        // R7: strobes ignored while deselected.
        wr_n = 1'b0; rd_n = 1'b0; addr = 20'h0F0F0;
        for (int i = 0; i < 6; i++) begin
            cycle();
            chk(cap_n == 1'b1 && mem_we_n == 1'b1 && ack == 1'b0, "R7 deselected",
                32'({cap_n, mem_we_n, ack}), 32'b110);
        end
        chk(mem_addr == 20'h33333, "R7 mem_addr", 32'(mem_addr), 32'h33333);
        wr_n = 1'b1; rd_n = 1'b1;
        cycle();

        // R11: write wins over read.
        sel_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; addr = 20'h77777; wdata = 16'h7777;
        cycle();
        chk(cap_n == 1'b0 && ack == 1'b0, "R11 write priority", 32'({cap_n, ack}), 0);
        chk(mem_addr == 20'h77777, "R11 mem_addr", 32'(mem_addr), 32'h77777);
        sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        for (int i = 0; i < 8; i++) cycle();
        exp_last = 20'h77777;
        chk(last_mem_addr == exp_last, "R11 committed", 32'(last_mem_addr), 32'(exp_last));

        // R10: reset in the middle of a memory strobe.
        sel_n = 1'b0; wr_n = 1'b0; addr = 20'h44444; wdata = 16'h4444;
        for (int i = 0; i < 4; i++) cycle();
        chk(mem_we_n == 1'b0, "R10 strobe active", 32'(mem_we_n), 0);
        rst_n = 1'b0;
        cycle();
        chk(mem_we_n == 1'b1 && ack == 1'b0 && cap_n == 1'b1, "R10 reset mid-write",
            32'({mem_we_n, ack, cap_n}), 32'b101);
        chk(last_mem_addr == '0 && mem_addr == '0, "R10 regs cleared",
            32'(last_mem_addr | mem_addr), 0);
        sel_n = 1'b1; wr_n = 1'b1; rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cycle();
            chk(mem_we_n == 1'b1 && ack == 1'b0, "R10 pending dropped",
                32'({mem_we_n, ack}), 32'b10);
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule